// File: doc/BRIEF.md
# Timer Capture/Compare Channel Register

This block is one channel of a 16-bit timer. A single data register serves two roles, and the `is_input` pin selects between them. In capture mode the register takes the running counter value whenever a qualified input event strobe arrives. Software writes to it are then dropped. The block keeps track of whether each capture has been read. A capture that lands on an unread one raises a sticky overcapture flag, and software clears that flag by writing 1 to it.

In compare mode the register holds a software-written compare value. An active compare copy is matched against the counter, and the block pulses `match_o` on each hit. The `preload_en` pin selects when a write reaches the active copy:
- with preload off, the active copy takes the write at the same clock edge as the register;
- with preload on, the active copy is reloaded from the register only on the counter overflow strobe.

Software reaches the block through a small port with a one-bit address. Address 0 is the data register. Address 1 is status, with the overcapture flag in bit 0. Reads are registered, so data appears one cycle after the request.

Top module: `cc_channel`

## Requirements
- R1: After reset, the data register reads 0x0000, status bit 0 reads 0, and `match_o` and `rdata` are 0.
- R2: `rdata` updates at the clock edge that samples `rd_en` high and keeps its value while `rd_en` is low.
- R3: In capture mode (`is_input`=1), `cap_i` high at an edge loads `cnt_i` into the data register, and a later read at address 0 returns that value.
- R4: In capture mode, writes to address 0 leave the data register unchanged.
- R5: When a capture and a read of address 0 share a cycle, the read returns the previous value and the new value is returned by the next read.
- R6: A capture that arrives while the previous capture has not been read at address 0 sets status bit 0. A capture that shares its cycle with a read of address 0 does not set it.
- R7: Writing a word with bit 0 = 1 to address 1 clears status bit 0, and writing bit 0 = 0 leaves it unchanged. If a write to clear the flag and a new overcapture share a cycle, the flag ends set.
- R8: In compare mode with `preload_en`=0, a write to address 0 becomes the active compare value at the same edge.
- R9: In compare mode with `preload_en`=1, the active compare value changes only at an edge with `ovf_i` high, where it takes the data register's value from before that edge. A write in the same cycle waits for the following overflow.
- R10: `match_o` is high in the cycle after a cycle in which the block is in compare mode and `cnt_i` equals the active compare value. It is low otherwise, and it is always low in the cycle after a capture-mode cycle.
- R11: In compare mode, a read of address 0 returns the last value written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_input | input | 1 | 1 = capture mode, 0 = compare mode |
| preload_en | input | 1 | 1 = compare writes wait for overflow |
| cnt_i | input | 16 | Running counter value |
| ovf_i | input | 1 | Counter overflow strobe |
| cap_i | input | 1 | Qualified input event strobe |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | 1 | 0 = data register, 1 = status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| match_o | output | 1 | Compare-match pulse |

## Verification
A stale active compare copy stays hidden until the counter reaches a value. `match_o` then fires on the old value, or fails to fire on the new one, one cycle after `cnt_i` is presented. The bench therefore steps `cnt_i` through both the old and the new compare values around every write and overflow. Wrong bookkeeping of the unread capture shows only at the next capture, and then only as status bit 0. For that reason every capture sequence is followed by a status read, including the capture that shares its cycle with a data read.

// File: rtl/cc_pkg.sv
// Package: shared register addresses and status field positions for the
// capture/compare channel. Assumes a one-bit register address.
package cc_pkg;
    typedef enum logic {
        CC_ADDR_DATA = 1'b0,
        CC_ADDR_STAT = 1'b1
    } cc_addr_e;

    localparam int CC_STAT_OVC_BIT = 0;
endpackage

// File: rtl/cc_datareg.sv
// Module: shared data register. In capture mode it takes the counter value
// on each capture strobe, tracks whether that capture has been read, and
// raises a sticky overcapture flag. In compare mode it is written by software.
// Assumes strobes are single-cycle and synchronous to clk.
module cc_datareg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_input,
    input  logic             cap_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_data_i,
    input  logic             wr_stat_i,
    input  logic [CNT_W-1:0] wdata,
    input  logic             rd_data_i,
    output logic [CNT_W-1:0] data_o,
    output logic             ovc_o
);
    import cc_pkg::*;

    logic [CNT_W-1:0] data_q;
    logic             pend_q;
    logic             ovc_q;
    logic             cap_ok;
    logic             ovc_set;

    assign cap_ok  = is_input && cap_i;
    assign ovc_set = cap_ok && pend_q && !rd_data_i;

    // Load the data register from a capture or from a compare-mode write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     data_q <= '0;
        else if (cap_ok)                data_q <= cnt_i;
        else if (wr_data_i && !is_input) data_q <= wdata;
    end

    // Track whether the latest capture has been read.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (cap_ok)    pend_q <= 1'b1;
        else if (rd_data_i) pend_q <= 1'b0;
    end

    // Sticky overcapture flag: setting wins over a write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovc_q <= 1'b0;
        else if (ovc_set) ovc_q <= 1'b1;
        else if (wr_stat_i && wdata[CC_STAT_OVC_BIT]) ovc_q <= 1'b0;
    end

    assign data_o = data_q;
    assign ovc_o  = ovc_q;

    // R3
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_input && cap_i) |=> (data_q == $past(cnt_i)));

    // R4
    input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_input && !cap_i) |=> $stable(data_q));

    // R6
    overcapture_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_input && cap_i && pend_q && !rd_data_i) |=> ovc_q);
endmodule

// File: rtl/cc_cmpreg.sv
// Module: active compare copy. It takes writes directly when preload is off,
// or reloads from the data register on overflow when preload is on.
// Assumes wr_i is already qualified with compare mode and address 0.
module cc_cmpreg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_input,
    input  logic             preload_en,
    input  logic             ovf_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] shadow_i,
    output logic [CNT_W-1:0] active_o
);
    logic [CNT_W-1:0] active_q;

    // Update the active compare value according to the preload setting.
    always_ff @(posedge clk) begin
        if (!rst_n)                              active_q <= '0;
        else if (!preload_en && wr_i)            active_q <= wdata;
        else if (preload_en && ovf_i && !is_input) active_q <= shadow_i;
    end

    assign active_o = active_q;

    // R8
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_en && wr_i) |=> (active_q == $past(wdata)));

    // R9
    preload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !ovf_i) |=> $stable(active_q));
endmodule

// File: rtl/cc_match.sv
// Module: compare-match detector. It registers the equality of the counter
// and the active compare value, and holds it at 0 in capture mode.
// Assumes the counter moves each cycle, so a hit lasts one cycle.
module cc_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_input,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] active_i,
    output logic             match_o
);
    logic match_q;

    // Register the compare hit.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= !is_input && (cnt_i == active_i);
    end

    assign match_o = match_q;

    // R10
    no_match_in_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_input |=> !match_q);
endmodule

// File: rtl/cc_channel.sv
// Module: capture/compare channel top. It decodes the register port, wires
// the data register, active compare copy and match detector together, and
// registers read data. Assumes one access per port per cycle.
module cc_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_input,
    input  logic             preload_en,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ovf_i,
    input  logic             cap_i,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             match_o
);
    import cc_pkg::*;

    localparam int STAT_PAD = CNT_W - 1;

    logic             wr_data, wr_stat, rd_data;
    logic [CNT_W-1:0] data_w, active_w, rdata_q;
    logic             ovc_w;

    assign wr_data = wr_en && (addr == CC_ADDR_DATA);
    assign wr_stat = wr_en && (addr == CC_ADDR_STAT);
    assign rd_data = rd_en && (addr == CC_ADDR_DATA);

    cc_datareg #(.CNT_W(CNT_W)) u_data (
        .clk(clk), .rst_n(rst_n), .is_input(is_input), .cap_i(cap_i),
        .cnt_i(cnt_i), .wr_data_i(wr_data), .wr_stat_i(wr_stat),
        .wdata(wdata), .rd_data_i(rd_data), .data_o(data_w), .ovc_o(ovc_w)
    );

    cc_cmpreg #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .is_input(is_input), .preload_en(preload_en),
        .ovf_i(ovf_i), .wr_i(wr_data && !is_input), .wdata(wdata),
        .shadow_i(data_w), .active_o(active_w)
    );

    cc_match #(.CNT_W(CNT_W)) u_match (
        .clk(clk), .rst_n(rst_n), .is_input(is_input), .cnt_i(cnt_i),
        .active_i(active_w), .match_o(match_o)
    );

    // Registered read: pre-edge register state is returned.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= (addr == CC_ADDR_DATA) ? data_w
                                   : {{STAT_PAD{1'b0}}, ovc_w};
    end

    assign rdata = rdata_q;

    // R2
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata_q));
endmodule

// File: tb/cc_channel_test.sv
module cc_channel_test;
    logic        clk = 0, rst_n = 0;
    logic        is_input = 0, preload_en = 0, ovf_i = 0, cap_i = 0;
    logic        wr_en = 0, rd_en = 0, addr = 0;
    logic [15:0] cnt_i = 16'hFFFF, wdata = 0;
    logic [15:0] rdata;
    logic        match_o;

    int tests = 0, fails = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_samp = 0;

    always #5 clk = ~clk;

    cc_channel uut (
        .clk(clk), .rst_n(rst_n), .is_input(is_input), .preload_en(preload_en),
        .cnt_i(cnt_i), .ovf_i(ovf_i), .cap_i(cap_i), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .match_o(match_o)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard one cycle after each sampled read.
    always @(posedge clk) rd_samp <= rd_en;
    always @(negedge clk) begin
        if (rd_samp) begin
            if (exp_q.size() == 0) chk("SCOREBOARD_EMPTY", 16'h1, 16'h0);
            else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(logic a, logic [15:0] exp, string tag);
        rd_en = 1; addr = a; exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wr(logic a, logic [15:0] d, logic with_ovf);
        wr_en = 1; addr = a; wdata = d; ovf_i = with_ovf;
        @(negedge clk); wr_en = 0; ovf_i = 0;
    endtask

    task automatic cap(logic [15:0] v);
        cnt_i = v; cap_i = 1;
        @(negedge clk); cap_i = 0; cnt_i = 16'hFFFF;
    endtask

    task automatic cnt_chk(logic [15:0] v, logic exp, string tag);
        cnt_i = v;
        @(negedge clk);
        chk(tag, {15'd0, match_o}, {15'd0, exp});
        cnt_i = 16'hFFFF;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL WATCHDOG: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        chk("R1 match after reset", {15'd0, match_o}, 16'h0);
        chk("R1 rdata after reset", rdata, 16'h0);
        rd(0, 16'h0000, "R1 data reset");
        rd(1, 16'h0000, "R1 status reset");

        // Compare mode, preload off
        wr(0, 16'h1234, 0);
        rd(0, 16'h1234, "R11 readback");
        idle(3);
        chk("R2 rdata held", rdata, 16'h1234);
        cnt_chk(16'h1234, 1, "R8 immediate match");
        cnt_chk(16'h1235, 0, "R10 no match");

        // Compare mode, preload on
        preload_en = 1;
        wr(0, 16'h0050, 0);
        cnt_chk(16'h0050, 0, "R9 new value not active");
        cnt_chk(16'h1234, 1, "R9 old value active");
        cnt_i = 0; ovf_i = 1; @(negedge clk); ovf_i = 0;
        cnt_chk(16'h0050, 1, "R9 active after ovf");
        wr(0, 16'h0077, 1);
        cnt_chk(16'h0077, 0, "R9 write+ovf waits");
        cnt_chk(16'h0050, 1, "R9 write+ovf keeps old");
        ovf_i = 1; @(negedge clk); ovf_i = 0;
        cnt_chk(16'h0077, 1, "R9 next ovf");
        rd(0, 16'h0077, "R11 preload readback");

        // Capture mode
        is_input = 1;
        cnt_chk(16'h0077, 0, "R10 no match in capture mode");
        wr(0, 16'hBEEF, 0);
        rd(0, 16'h0077, "R4 write ignored");
        cap(16'h0AAA);
        rd(0, 16'h0AAA, "R3 captured value");
        rd(1, 16'h0000, "R6 no overcapture");
        cap(16'h0BBB);
        cap(16'h0CCC);
        rd(1, 16'h0001, "R6 overcapture set");
        rd(0, 16'h0CCC, "R3 latest capture");
        wr(1, 16'h0000, 0);
        rd(1, 16'h0001, "R7 write 0 keeps flag");
        wr(1, 16'h0001, 0);
        rd(1, 16'h0000, "R7 write 1 clears flag");

        // Capture and read in one cycle
        cap(16'h0111);
        cnt_i = 16'h0222; cap_i = 1; rd_en = 1; addr = 0;
        exp_q.push_back(16'h0111); tag_q.push_back("R5 old value on same-cycle read");
        @(negedge clk); cap_i = 0; rd_en = 0; cnt_i = 16'hFFFF;
        rd(1, 16'h0000, "R6 no overcapture when read same cycle");
        rd(0, 16'h0222, "R5 new value next read");

        // Set wins over clear
        cap(16'h0333);
        cnt_i = 16'h0444; cap_i = 1; wr_en = 1; addr = 1; wdata = 16'h0001;
        @(negedge clk); cap_i = 0; wr_en = 0; cnt_i = 16'hFFFF;
        rd(1, 16'h0001, "R7 set wins over clear");

        idle(3);
        chk("R2 scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule